// File: doc/BRIEF.md
# Indexed Pixel Pipeline with Cursor

This block turns a frame of 8-bit colour indices held in video memory into a stream of 24-bit RGB pixels, one per clock. A pulse on `frame_start` begins a frame. The scan walks the active area row by row and reads video memory as one linear byte stream. That stream begins at a programmable byte offset, so moving the offset pans the picture vertically. Each byte fetched is looked up in a 256-entry colour table.

A 64×64 pointer with two bits per pixel is drawn over the picture and takes its colours from a small three-entry table. A force-blank control turns every pixel black. After the last pixel, the block raises a one-clock end-of-frame pulse and sets a sticky frame interrupt that an acknowledge input clears.

All four memories sit outside the block and are reached through synchronous read ports. Each port returns data one clock after the address. The pipeline carries its valid, cursor and last-pixel flags alongside the data so that they stay aligned. Sync timing is handled elsewhere.

Top module: `idx_pixel_pipe`

## Requirements
- R1: After reset `pix_valid`, `frame_end`, `frame_irq` and `vram_rd` are low. An accepted frame yields exactly width×height cycles with `pix_valid` high.
- R2: Video memory is read linearly, one byte per pixel. The first byte is at `cfg_top`, and rows follow back to back, width bytes each. The pixel at (x, y) comes from address `cfg_top + y·width + x`.
- R3: Outside the cursor area, a pixel equals the colour-table entry addressed by its video byte.
- R4: `cursor_pos[23:12]` is the cursor X and `cursor_pos[11:0]` is the cursor Y. A pixel is in the cursor area when Y ≤ y < Y+64 and X ≤ x < X+64. Parts of the area beyond the active area are simply not drawn.
- R5: Inside the area, the pattern word index is (y−Y)·8 + (x−X)/8. The 2-bit code is bits [2·((x−X) mod 8) +: 2] of that word, so the lowest bits hold the leftmost pixel.
- R6: Code 0 is transparent and shows the colour-table value. Codes 1, 2 and 3 select cursor colour entries 0, 1 and 2.
- R7: While `cfg_cursor_off` is 1, no pixel is treated as inside the cursor area.
- R8: While `cfg_blank` is 1, every valid pixel is 0 and the valid count is unchanged.
- R9: `frame_start` is ignored while width or height is 0: no reads, no valid pixels, no end-of-frame pulse.
- R10: Only depth code 3 (8 bits per pixel) renders. With any other code `frame_start` is ignored.
- R11: `frame_end` is high for exactly one clock, the clock right after the last valid pixel of the frame.
- R12: `frame_irq` is set together with `frame_end` and stays set until `irq_clr` is sampled high.
- R13: A `frame_start` that arrives while a frame is being scanned is ignored. The frame still yields width×height pixels and one end-of-frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Begin a frame |
| cfg_width | input | 12 | Active width in pixels |
| cfg_height | input | 12 | Active height in lines |
| cfg_top | input | 20 | Byte offset of the first pixel |
| cfg_depth | input | 3 | Depth code; 3 means 8 bits per pixel |
| cfg_blank | input | 1 | Force all pixels to black |
| cfg_cursor_off | input | 1 | Disable the cursor overlay |
| cursor_pos | input | 24 | Packed cursor X (high 12 bits) and Y (low 12 bits) |
| vram_rd | output | 1 | Video memory read strobe |
| vram_addr | output | 20 | Video memory byte address |
| vram_data | input | 8 | Video byte, one clock after the address |
| pal_addr | output | 8 | Colour-table index |
| pal_data | input | 24 | Colour-table RGB, one clock after the address |
| cpat_addr | output | 9 | Cursor pattern word index |
| cpat_data | input | 16 | Pattern word, one clock after the address |
| cpal_addr | output | 2 | Cursor colour entry |
| cpal_data | input | 24 | Cursor colour RGB, one clock after the address |
| irq_clr | input | 1 | Clear the frame interrupt |
| pix_rgb | output | 24 | Output pixel |
| pix_valid | output | 1 | Output pixel is valid |
| frame_end | output | 1 | One-clock pulse after the last pixel |
| frame_irq | output | 1 | Sticky frame interrupt |

## Verification
The assertions assume that every external memory answers exactly one clock after its address. They also assume that width, height, offset, depth and cursor position stay constant while a frame is being scanned. The blank check further assumes that `cfg_blank` does not change in the clock before a pixel leaves the block.

The bench models the four memories as clocked reads. It changes configuration only between frames, waiting out the pipeline tail each time. The one exception is the deliberate mid-frame `frame_start`, which checks that a second start is ignored.

// File: rtl/pix_pkg.sv
package pix_pkg;
    localparam int RGB_W = 24;
    typedef logic [RGB_W-1:0] rgb_t;
    localparam logic [2:0] DEPTH_8BPP = 3'd3;
    localparam int CUR_SZ = 64;
    localparam int CUR_LG = $clog2(CUR_SZ);
    localparam int PIX_PER_WORD = 8;
endpackage

// File: rtl/pix_scan.sv
module pix_scan #(
    parameter int CW = 12,
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] cfg_w,
    input  logic [CW-1:0] cfg_h,
    input  logic [AW-1:0] cfg_top,
    input  logic [2:0]    depth,
    output logic          act,
    output logic [CW-1:0] x,
    output logic [CW-1:0] y,
    output logic [AW-1:0] addr,
    output logic          last
);
    import pix_pkg::*;

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic          act;
        logic [CW-1:0] x;
        logic [CW-1:0] y;
        logic [AW-1:0] a;
    } scan_t;

    scan_t scan_d, scan_q;
    logic  row_end, col_end;

    always_comb begin
        scan_d  = scan_q;
        row_end = (scan_q.x == cfg_w - ONE);
        col_end = (scan_q.y == cfg_h - ONE);
        if (scan_q.act) begin
            scan_d.a = scan_q.a + {{(AW-1){1'b0}}, 1'b1};
            if (row_end) begin
                scan_d.x = '0;
                scan_d.y = scan_q.y + ONE;
                if (col_end) scan_d.act = 1'b0;
            end else begin
                scan_d.x = scan_q.x + ONE;
            end
        end else if (start && cfg_w != '0 && cfg_h != '0 && depth == DEPTH_8BPP) begin
            scan_d.act = 1'b1;
            scan_d.x   = '0;
            scan_d.y   = '0;
            scan_d.a   = cfg_top;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) scan_q <= '0;
        else        scan_q <= scan_d;
    end

    assign act  = scan_q.act;
    assign x    = scan_q.x;
    assign y    = scan_q.y;
    assign addr = scan_q.a;
    assign last = scan_q.act && row_end && col_end;

    // R2
    addr_linear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && $past(act)) |-> (addr == $past(addr) + {{(AW-1){1'b0}}, 1'b1}));

    // R9
    zero_size_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && start && (cfg_w == '0 || cfg_h == '0)) |=> !act);

    // R10
    depth_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && start && depth != DEPTH_8BPP) |=> !act);
endmodule

// File: rtl/pix_cursor.sv
module pix_cursor #(
    parameter int CW = 12,
    parameter int PW = 9
) (
    input  logic [CW-1:0]   x,
    input  logic [CW-1:0]   y,
    input  logic [2*CW-1:0] pos,
    input  logic            off,
    output logic            hit,
    output logic [PW-1:0]   word,
    output logic [2:0]      sub
);
    import pix_pkg::*;

    logic [CW-1:0]     xc, yc;
    logic [CW:0]       x_lim, y_lim;
    logic              in_x, in_y;
    logic [CUR_LG-1:0] dx, dy;

    always_comb begin
        xc    = pos[2*CW-1:CW];
        yc    = pos[CW-1:0];
        x_lim = {1'b0, xc} + (CW+1)'(CUR_SZ);
        y_lim = {1'b0, yc} + (CW+1)'(CUR_SZ);
        in_x  = (x >= xc) && ({1'b0, x} < x_lim);
        in_y  = (y >= yc) && ({1'b0, y} < y_lim);
        hit   = !off && in_x && in_y;
        dx    = x[CUR_LG-1:0] - xc[CUR_LG-1:0];
        dy    = y[CUR_LG-1:0] - yc[CUR_LG-1:0];
        word  = {dy, dx[CUR_LG-1:3]};
        sub   = dx[2:0];
    end
endmodule

// File: rtl/idx_pixel_pipe.sv
module idx_pixel_pipe #(
    parameter int CW = 12,
    parameter int AW = 20,
    localparam int PW = 2 * pix_pkg::CUR_LG - $clog2(pix_pkg::PIX_PER_WORD)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic [CW-1:0]        cfg_width,
    input  logic [CW-1:0]        cfg_height,
    input  logic [AW-1:0]        cfg_top,
    input  logic [2:0]           cfg_depth,
    input  logic                 cfg_blank,
    input  logic                 cfg_cursor_off,
    input  logic [2*CW-1:0]      cursor_pos,
    output logic                 vram_rd,
    output logic [AW-1:0]        vram_addr,
    input  logic [7:0]           vram_data,
    output logic [7:0]           pal_addr,
    input  logic [23:0]          pal_data,
    output logic [PW-1:0]        cpat_addr,
    input  logic [15:0]          cpat_data,
    output logic [1:0]           cpal_addr,
    input  logic [23:0]          cpal_data,
    input  logic                 irq_clr,
    output logic [23:0]          pix_rgb,
    output logic                 pix_valid,
    output logic                 frame_end,
    output logic                 frame_irq
);
    import pix_pkg::*;

    typedef struct packed {
        logic       v1;
        logic       hit1;
        logic       last1;
        logic [2:0] sub1;
        logic       v2;
        logic       last2;
        logic [1:0] code2;
        logic       v3;
        logic       last3;
        rgb_t       rgb3;
        logic       eof;
        logic       irq;
    } pipe_t;

    pipe_t         pipe_d, pipe_q;
    logic          s_act, s_last, c_hit;
    logic [CW-1:0] s_x, s_y;
    logic [2:0]    c_sub;
    logic [1:0]    code1;

    pix_scan #(.CW(CW), .AW(AW)) i_scan (
        .clk(clk), .rst_n(rst_n), .start(frame_start),
        .cfg_w(cfg_width), .cfg_h(cfg_height), .cfg_top(cfg_top),
        .depth(cfg_depth), .act(s_act), .x(s_x), .y(s_y),
        .addr(vram_addr), .last(s_last)
    );

    pix_cursor #(.CW(CW), .PW(PW)) i_cursor (
        .x(s_x), .y(s_y), .pos(cursor_pos), .off(cfg_cursor_off),
        .hit(c_hit), .word(cpat_addr), .sub(c_sub)
    );

    assign vram_rd = s_act;

    always_comb begin
        pipe_d    = pipe_q;
        code1     = pipe_q.hit1 ? cpat_data[{pipe_q.sub1, 1'b0} +: 2] : 2'd0;
        pal_addr  = vram_data;
        cpal_addr = code1 - 2'd1;
        // stage 1: addresses presented, flags follow the fetch
        pipe_d.v1    = s_act;
        pipe_d.hit1  = c_hit;
        pipe_d.last1 = s_last;
        pipe_d.sub1  = c_sub;
        // stage 2: index and cursor code known, colour lookups issued
        pipe_d.v2    = pipe_q.v1;
        pipe_d.last2 = pipe_q.v1 && pipe_q.last1;
        pipe_d.code2 = code1;
        // stage 3: pick the colour
        pipe_d.v3    = pipe_q.v2;
        pipe_d.last3 = pipe_q.v2 && pipe_q.last2;
        if (cfg_blank)                pipe_d.rgb3 = '0;
        else if (pipe_q.code2 != 2'd0) pipe_d.rgb3 = cpal_data;
        else                          pipe_d.rgb3 = pal_data;
        // frame completion
        pipe_d.eof = pipe_q.v3 && pipe_q.last3;
        pipe_d.irq = (pipe_q.irq && !irq_clr) || pipe_d.eof;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign pix_rgb   = pipe_q.rgb3;
    assign pix_valid = pipe_q.v3;
    assign frame_end = pipe_q.eof;
    assign frame_irq = pipe_q.irq;

    // R11
    eof_after_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> $past(pix_valid));

    // R11
    eof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    // R12
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_irq) |-> frame_end);

    // R12
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_irq && !irq_clr) |=> frame_irq);

    // R8
    blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(cfg_blank)) |-> (pix_rgb == '0));
endmodule

// File: tb/test_idx_pixel_pipe.sv
module test_idx_pixel_pipe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [11:0] cfg_width = '0, cfg_height = '0;
    logic [19:0] cfg_top = '0;
    logic [2:0]  cfg_depth = 3'd3;
    logic        cfg_blank = 1'b0, cfg_cursor_off = 1'b1;
    logic [23:0] cursor_pos = '0;
    logic        vram_rd;
    logic [19:0] vram_addr;
    logic [7:0]  vram_data;
    logic [7:0]  pal_addr;
    logic [23:0] pal_data;
    logic [8:0]  cpat_addr;
    logic [15:0] cpat_data;
    logic [1:0]  cpal_addr;
    logic [23:0] cpal_data;
    logic        irq_clr = 1'b0;
    logic [23:0] pix_rgb;
    logic        pix_valid, frame_end, frame_irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [15:0] cpat [512];

    always #10 clk = ~clk;

    idx_pixel_pipe i_idx_pixel_pipe (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_top(cfg_top),
        .cfg_depth(cfg_depth), .cfg_blank(cfg_blank),
        .cfg_cursor_off(cfg_cursor_off), .cursor_pos(cursor_pos),
        .vram_rd(vram_rd), .vram_addr(vram_addr), .vram_data(vram_data),
        .pal_addr(pal_addr), .pal_data(pal_data),
        .cpat_addr(cpat_addr), .cpat_data(cpat_data),
        .cpal_addr(cpal_addr), .cpal_data(cpal_data),
        .irq_clr(irq_clr), .pix_rgb(pix_rgb), .pix_valid(pix_valid),
        .frame_end(frame_end), .frame_irq(frame_irq)
    );

    function automatic logic [7:0] vram_fn(int a);
        return 8'((a & 20'hFFFFF) * 7 + 3);
    endfunction
    function automatic logic [23:0] pal_fn(logic [7:0] i);
        return {i, i ^ 8'hFF, i + 8'h33};
    endfunction
    function automatic logic [23:0] cpal_fn(logic [1:0] i);
        case (i)
            2'd0:    return 24'hFF0000;
            2'd1:    return 24'h00FF00;
            2'd2:    return 24'h0000FF;
            default: return 24'hDEAD00;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        vram_data <= vram_fn(int'(vram_addr));
        pal_data  <= pal_fn(pal_addr);
        cpat_data <= cpat[cpat_addr];
        cpal_data <= cpal_fn(cpal_addr);
    end

    function automatic logic [23:0] exp_px(int x, int y, int w, int top);
        int cx, cy, wi, code;
        cx = int'(cursor_pos[23:12]);
        cy = int'(cursor_pos[11:0]);
        if (cfg_blank) return 24'h0;
        if (!cfg_cursor_off && x >= cx && x < cx + 64 && y >= cy && y < cy + 64) begin
            wi   = (y - cy) * 8 + (x - cx) / 8;
            code = int'((cpat[wi] >> (2 * ((x - cx) % 8))) & 16'h3);
            if (code != 0) return cpal_fn(2'(code - 1));
        end
        return pal_fn(vram_fn(top + y * w + x));
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(int w, int h, int top, string req, bit restart);
        int k = 0, eofs = 0;
        bit prev_v = 1'b0;
        cfg_width  = 12'(w);
        cfg_height = 12'(h);
        cfg_top    = 20'(top);
        @(negedge clk) frame_start = 1'b1;
        for (int c = 0; c < w * h + 40; c++) begin
            @(negedge clk);
            frame_start = restart && (c == 10);
            if (pix_valid) begin
                if (k < w * h)
                    chk(pix_rgb == exp_px(k % w, k / w, w, top), req, "pixel colour",
                        32'(pix_rgb), 32'(exp_px(k % w, k / w, w, top)));
                k++;
            end
            if (frame_end) begin
                eofs++;
                chk(prev_v && k == w * h, "R11", "end pulse after last pixel",
                    32'(k), 32'(w * h));
            end
            prev_v = pix_valid;
        end
        frame_start = 1'b0;
        chk(k == w * h, "R1", "valid pixel count", 32'(k), 32'(w * h));
        chk(eofs == 1, "R11", "end pulse count", 32'(eofs), 32'd1);
    endtask

    task automatic t_reset;
        chk(!pix_valid && !frame_end && !frame_irq && !vram_rd, "R1", "reset outputs",
            {28'd0, pix_valid, frame_end, frame_irq, vram_rd}, 32'd0);
    endtask

    task automatic t_plain;
        cfg_cursor_off = 1'b1;
        run_frame(16, 4, 0, "R3", 1'b0);
    endtask

    task automatic t_pan;
        run_frame(8, 3, 1000, "R2", 1'b0);
    endtask

    task automatic t_cursor_inside;
        for (int i = 0; i < 512; i++) cpat[i] = 16'(i * 40503 + 12345);
        cfg_cursor_off = 1'b0;
        cursor_pos = {12'd10, 12'd5};
        run_frame(80, 70, 0, "R5", 1'b0);
    endtask

    task automatic t_cursor_clipped;
        cursor_pos = {12'd60, 12'd50};
        run_frame(80, 70, 37, "R4", 1'b0);
    endtask

    task automatic t_cursor_codes;
        // each word shows codes 0,1,2,3 left to right, twice
        for (int i = 0; i < 512; i++) cpat[i] = 16'hE4E4;
        cursor_pos = {12'd2, 12'd1};
        run_frame(20, 6, 0, "R6", 1'b0);
    endtask

    task automatic t_cursor_off;
        cfg_cursor_off = 1'b1;
        run_frame(20, 6, 0, "R7", 1'b0);
    endtask

    task automatic t_blank;
        cfg_blank = 1'b1;
        run_frame(12, 5, 3, "R8", 1'b0);
        cfg_blank = 1'b0;
    endtask

    task automatic t_idle(int w, int h, logic [2:0] d, string req);
        int bad = 0;
        cfg_width  = 12'(w);
        cfg_height = 12'(h);
        cfg_depth  = d;
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (pix_valid || vram_rd || frame_end) bad++;
        end
        chk(bad == 0, req, "start ignored", 32'(bad), 32'd0);
        cfg_depth = 3'd3;
    endtask

    task automatic t_irq;
        chk(frame_irq == 1'b1, "R12", "irq set after frame", 32'(frame_irq), 32'd1);
        repeat (3) @(negedge clk);
        chk(frame_irq == 1'b1, "R12", "irq held", 32'(frame_irq), 32'd1);
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        chk(frame_irq == 1'b0, "R12", "irq cleared", 32'(frame_irq), 32'd0);
    endtask

    task automatic t_restart;
        run_frame(10, 4, 5, "R13", 1'b1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) cpat[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_irq();
        t_pan();
        t_cursor_inside();
        t_cursor_clipped();
        t_cursor_codes();
        t_cursor_off();
        t_blank();
        t_idle(0, 5, 3'd3, "R9");
        t_idle(6, 0, 3'd3, "R9");
        t_idle(6, 4, 3'd2, "R10");
        t_restart();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule